// File: doc/BRIEF.md
# Infrared Serial Pulse Encoder

This block sits between a UART transmitter and an infrared emitter driver. Each bit period of the serial transmit stream is split into equal sub-ticks, which an external baud generator supplies as a one-clock strobe. A data bit of logic 0 is sent as a single short high pulse at the start of its period. A data bit of logic 1 leaves the line low for the whole period. Between pulses the output rests low.

A two-bit select picks the pulse width as a fraction of the bit time: 3/16, 1/16, 1/32 or 1/4. With the default of 32 sub-ticks per bit, these are 6, 2, 1 and 8 sub-ticks. The data bit and the width select are both captured on the first sub-tick of each period. A width change made mid-period therefore applies from the next period, and a pulse that has started runs to its full length. When the encoder is disabled, or held in reset, the output is forced low and the period count starts over.

Top module: `ir_pulse_encoder`

## Requirements
- R1: While reset is asserted, and after it is released, `ir_out` is 0 until a period starts with a 0 data bit.
- R2: Width select code 2'b00 gives a high pulse of 6 sub-ticks, which is 3/16 of a 32-sub-tick bit.
- R3: Width select code 2'b01 gives a high pulse of 2 sub-ticks, which is 1/16 of the bit.
- R4: Width select code 2'b10 gives a high pulse of 1 sub-tick, which is 1/32 of the bit.
- R5: Width select code 2'b11 gives a high pulse of 8 sub-ticks, which is 1/4 of the bit.
- R6: A period whose data bit is 1 produces no pulse. `ir_out` stays 0 for all of its sub-ticks.
- R7: A pulse starts on the first sub-tick of a period. `ir_out` rises in the clock after that sub-tick strobe and changes only in the clock after a sub-tick strobe, or when the encoder is disabled.
- R8: `width_sel` is sampled only on the first sub-tick of a period. A change at any other time does not alter the pulse in progress. A change on the first sub-tick applies to that same period.
- R9: While `enable` is 0, `ir_out` is 0 from the next clock. After `enable` returns to 1, the next sub-tick strobe starts a new period.
- R10: `tx_bit` is sampled only on the first sub-tick of a period. Changing it mid-period has no effect on `ir_out` in that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sub_tick | input | 1 | One-clock strobe per sub-tick from the baud generator |
| enable | input | 1 | Encoder enable; when 0, the output is forced low |
| tx_bit | input | 1 | Serial transmit data bit |
| width_sel | input | 2 | Pulse width select code |
| ir_out | output | 1 | Pulse-coded infrared transmit line |

## Verification
Two events can land in the same cycle: the capture of a new width and data bit at a period boundary, and an update to those same inputs by the stimulus. The bench changes `width_sel` and `tx_bit` in exactly the clock whose sub-tick strobe starts a period, and also changes them several sub-ticks into a period. In the first case the new pulse must take the new width at once. In the second case it must keep the old width. A behavioural model compares `ir_out` on every clock, and the high time of each period is also measured against the width expected for the code in force.

// File: rtl/ir_pulse_encoder.sv
module ir_pulse_encoder #(
  parameter int SUBTICKS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sub_tick,
  input  logic       enable,
  input  logic       tx_bit,
  input  logic [1:0] width_sel,
  output logic       ir_out
);
  localparam int PW = $clog2(SUBTICKS);
  localparam logic [PW-1:0] LAST    = PW'(SUBTICKS - 1);
  localparam logic [PW-1:0] LEN_316 = PW'(3 * SUBTICKS / 16);
  localparam logic [PW-1:0] LEN_116 = PW'(SUBTICKS / 16);
  localparam logic [PW-1:0] LEN_132 = PW'(SUBTICKS / 32);
  localparam logic [PW-1:0] LEN_14  = PW'(SUBTICKS / 4);

  logic [PW-1:0] phase;
  logic [PW-1:0] len_q;
  logic          bit_q;
  logic [PW-1:0] len_sel;

  always_comb begin
    case (width_sel)
      2'b00:   len_sel = LEN_316;
      2'b01:   len_sel = LEN_116;
      2'b10:   len_sel = LEN_132;
      default: len_sel = LEN_14;
    endcase
  end

  wire at_start = (phase == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      len_q  <= LEN_316;
      bit_q  <= 1'b1;
      ir_out <= 1'b0;
    end else if (!enable) begin
      phase  <= '0;
      ir_out <= 1'b0;
    end else if (sub_tick) begin
      phase <= (phase == LAST) ? '0 : phase + 1'b1;
      if (at_start) begin
        bit_q  <= tx_bit;
        len_q  <= len_sel;
        ir_out <= ~tx_bit;
      end else begin
        ir_out <= ~bit_q && (phase < len_q);
      end
    end
  end
endmodule

// File: rtl/ir_pulse_encoder_chk.sv
module ir_pulse_encoder_chk #(
  parameter int SUBTICKS = 32
) (
  input logic clk,
  input logic rst_n,
  input logic sub_tick,
  input logic enable,
  input logic tx_bit,
  input logic ir_out
);
  localparam int CW = $clog2(SUBTICKS) + 1;
  logic [CW-1:0] hi_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hi_ticks <= '0;
    else if (!ir_out)           hi_ticks <= '0;
    else if (sub_tick)          hi_ticks <= hi_ticks + 1'b1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> !ir_out); // R1
  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hi_ticks <= CW'(SUBTICKS / 4)); // R5
  AST_ONE_BIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_out) |-> $past(!tx_bit)); // R6
  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_out) |-> $past(sub_tick)); // R7
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !sub_tick) |=> $stable(ir_out)); // R7
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !ir_out); // R9
endmodule

bind ir_pulse_encoder ir_pulse_encoder_chk #(.SUBTICKS(SUBTICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .enable(enable),
  .tx_bit(tx_bit), .ir_out(ir_out)
);

// File: tb/ir_pulse_encoder_test.sv
module ir_pulse_encoder_test;
  localparam int S   = 32;
  localparam int GAP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic tx_bit = 1'b1;
  logic [1:0] width_sel = 2'b00;
  logic ir_out;
  logic run = 1'b0;
  int   tcnt = 0;
  wire  sub_tick = run && (tcnt == 0);

  int compared = 0, mismatched = 0, cycles = 0;
  string req = "R1";
  int m_ph = 0, m_len = 6, m_exp = 0;
  logic m_bit = 1'b1;

  ir_pulse_encoder #(.SUBTICKS(S)) uut (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .enable(enable),
    .tx_bit(tx_bit), .width_sel(width_sel), .ir_out(ir_out)
  );

  always #2.5 clk = ~clk;

  function automatic int len_of(input logic [1:0] c);
    case (c)
      2'b00: return 6;
      2'b01: return 2;
      2'b10: return 1;
      default: return 8;
    endcase
  endfunction

  always @(posedge clk) tcnt <= (tcnt == GAP - 1) ? 0 : tcnt + 1;

  always @(posedge clk) begin
    if (!rst_n || !enable) begin
      m_ph = 0; m_exp = 0;
    end else if (sub_tick) begin
      if (m_ph == 0) begin
        m_bit = tx_bit; m_len = len_of(width_sel); m_exp = tx_bit ? 0 : 1;
      end else begin
        m_exp = (!m_bit && m_ph < m_len) ? 1 : 0;
      end
      m_ph = (m_ph + 1) % S;
    end
  end

  always @(negedge clk) begin
    cycles++;
    compared++;
    if (ir_out !== m_exp[0]) begin
      mismatched++;
      $display("FAIL %s cycle %0d: ir_out=%b expected=%0d", req, cycles, ir_out, m_exp);
    end
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog: ir_out=%b expected=finish", ir_out);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic to_boundary();
    do @(negedge clk); while (!(m_ph == 0 && sub_tick && enable));
  endtask

  task automatic check_high(input string r, input int exp_ticks, input int mid_after,
                            input logic [1:0] mid_sel, input logic mid_bit);
    int hi = 0;
    for (int i = 0; i < S * GAP; i++) begin
      @(negedge clk);
      if (ir_out === 1'b1) hi++;
      if (i == mid_after) begin width_sel = mid_sel; tx_bit = mid_bit; end
    end
    compared++;
    if (hi != exp_ticks * GAP) begin
      mismatched++;
      $display("FAIL %s high clocks: actual=%0d expected=%0d", r, hi, exp_ticks * GAP);
    end
  endtask

  task automatic send(input string r, input logic b, input logic [1:0] c,
                      input int mid_after, input logic [1:0] mid_sel, input logic mid_bit);
    req = r;
    to_boundary();
    tx_bit = b; width_sel = c;
    check_high(r, b ? 0 : len_of(c), mid_after, mid_sel, mid_bit);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    compared++;
    if (ir_out !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 in reset: actual=%b expected=0", ir_out);
    end
    rst_n = 1'b1; run = 1'b1;
    repeat (10) @(negedge clk);
    enable = 1'b1;
    send("R2", 1'b0, 2'b00, -1, 2'b00, 1'b0);
    send("R3", 1'b0, 2'b01, -1, 2'b01, 1'b0);
    send("R4", 1'b0, 2'b10, -1, 2'b10, 1'b0);
    send("R5", 1'b0, 2'b11, -1, 2'b11, 1'b0);
    send("R6", 1'b1, 2'b11, -1, 2'b11, 1'b1);
    send("R6", 1'b1, 2'b00, -1, 2'b00, 1'b1);
    send("R7", 1'b0, 2'b00, -1, 2'b00, 1'b0);
    // R8: mid-period change of width must not alter the running pulse
    send("R8", 1'b0, 2'b01, 3 * GAP, 2'b11, 1'b0);
    send("R8", 1'b0, 2'b00, 2, 2'b10, 1'b0);
    // R8: width change right on the boundary tick applies at once
    send("R8", 1'b0, 2'b11, -1, 2'b11, 1'b0);
    // R10: data bit toggled mid-period is ignored
    send("R10", 1'b1, 2'b11, 4 * GAP, 2'b11, 1'b0);
    send("R10", 1'b0, 2'b11, 2 * GAP, 2'b11, 1'b1);
    send("R2", 1'b0, 2'b00, -1, 2'b00, 1'b1);
    // R9: disable during a pulse
    req = "R9";
    to_boundary();
    tx_bit = 1'b0; width_sel = 2'b11;
    repeat (2 * GAP) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    compared++;
    if (ir_out !== 1'b0) begin
      mismatched++;
      $display("FAIL R9 disabled: actual=%b expected=0", ir_out);
    end
    repeat (40) @(negedge clk);
    enable = 1'b1;
    send("R9", 1'b0, 2'b01, -1, 2'b01, 1'b0);
    send("R4", 1'b0, 2'b10, -1, 2'b10, 1'b0);
    repeat (10) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule